// File: doc/BRIEF.md
# Tiled View Address Generator

This block converts a pixel position inside a two-dimensional tiled container into the 32-bit address used to reach that pixel through one of eight rotated or mirrored views. A request carries a pixel format (8-bit, 16-bit or 32-bit tiled, or page mode), a 3-bit orientation code and the X and Y coordinates. One clock later the block returns the tiled address, a flag that tells whether the coordinates lay inside the container for that format, and the line stride that a display or copy engine must use to walk the same view.

Each format fixes how many low coordinate bits are folded into the pixel size. This sets the usable coordinate range, the packing of the offset, and how far the offset is shifted before the format and view fields are placed above it. Mirroring folds a coordinate within its range, and a flip swaps the roles of X and Y so that columns become lines.

Top module: `tvag_top`

## Requirements
- R1: A request presented with `in_valid` high yields `out_valid` high exactly one clock later with its results; when `in_valid` is low, `out_valid` is low on the next clock and `addr_o`, `in_range_o` and `stride_o` keep their previous values.
- R2: For an in-range request, address bits [28:27] hold the format code: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = page mode.
- R3: For an in-range request, address bits [31:29] hold the 3-bit orientation code unchanged (0 plain, 1 180° mirrored, 2 0° mirrored, 3 180°, 4 270° mirrored, 5 270°, 6 90°, 7 90° mirrored).
- R4: Per format, the X and Y shifts are (0,0) for 8-bit, (0,1) for 16-bit, (1,1) for 32-bit and (6,6) for page mode; the usable X bit count is 14 minus the X shift and the usable Y bit count is 13 minus the Y shift.
- R5: If X exceeds its mask (2^xbits − 1) or Y exceeds its mask (2^ybits − 1), `in_range_o` is 0 and `addr_o` is 0; otherwise `in_range_o` is 1.
- R6: Orientation bit 0 replaces X by X XOR its mask; orientation bit 1 replaces Y by Y XOR its mask.
- R7: With orientation bit 2 clear the offset is Y·2^xbits + X; with it set the offset is X·2^ybits + Y (after any mirroring).
- R8: The offset is shifted left by the sum of the X and Y shifts and occupies bits [26:0] of the address.
- R9: `stride_o` is 2^(13 + X shift) when orientation bit 2 is set and 2^(14 + Y shift) otherwise, independent of the coordinate range check.
- R10: While reset is active and on the first clock after it, `out_valid`, `in_range_o`, `addr_o` and `stride_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| fmt_i | input | 2 | Pixel format code |
| orient_i | input | 3 | View code: bit 0 X-invert, bit 1 Y-invert, bit 2 XY-flip |
| x_i | input | 16 | Pixel X coordinate |
| y_i | input | 16 | Pixel Y coordinate |
| out_valid | output | 1 | Result strobe, one clock after the request |
| addr_o | output | 32 | Tiled address, 0 when out of range |
| in_range_o | output | 1 | Coordinates were inside the container |
| stride_o | output | 32 | Line stride of the view in bytes |

## Verification
Mirroring and flipping can act on the same request, and the flip then packs the already mirrored coordinates with the swapped bit counts; the bench drives all eight orientation codes at both coordinate extremes of every format, where a wrong order of mirror and flip changes the result. Range rejection and stride generation also fall in the same cycle: an out-of-range request must zero the address while still reporting the stride of its format and orientation, which the bench provokes with coordinates one above each mask. Every returned value is compared with a behavioural model that folds with subtraction and packs with multiplication.

// File: rtl/tvag_pkg.sv
// Package: shared format codes and orientation bit positions of the
// tiled view address generator. Assumes a 2-bit format and 3-bit view code.
package tvag_pkg;
    typedef enum logic [1:0] {
        FMT_B8   = 2'd0,
        FMT_B16  = 2'd1,
        FMT_B32  = 2'd2,
        FMT_PAGE = 2'd3
    } tvag_fmt_e;

    localparam int NUM_FMT   = 4;
    localparam int OR_XINV   = 0;
    localparam int OR_YINV   = 1;
    localparam int OR_FLIP   = 2;
    localparam int SHIFT_W   = 5;
endpackage

// File: rtl/tvag_geom.sv
// Geometry decoder: maps a format code to its X/Y shifts, usable bit counts
// and coordinate masks. Purely combinational. Assumes CW_BITS and CH_BITS
// exceed the page-mode slot bits.
module tvag_geom #(
    parameter int CW_BITS = 14,
    parameter int CH_BITS = 13,
    parameter int SW_BITS = 6,
    parameter int SH_BITS = 6
) (
    input  logic [1:0]                  fmt,
    output logic [tvag_pkg::SHIFT_W-1:0] xs,
    output logic [tvag_pkg::SHIFT_W-1:0] ys,
    output logic [tvag_pkg::SHIFT_W-1:0] xbits,
    output logic [tvag_pkg::SHIFT_W-1:0] ybits,
    output logic [31:0]                 xmask,
    output logic [31:0]                 ymask
);
    import tvag_pkg::*;

    logic [SHIFT_W-1:0] xs_tab [NUM_FMT];
    logic [SHIFT_W-1:0] ys_tab [NUM_FMT];

    // Build the per-format shift table, one entry per format code.
    for (genvar f = 0; f < NUM_FMT; f++) begin : g_tab
        localparam int XSH = (f == 0) ? 0 : (f == 1) ? 0 : (f == 2) ? 1 : SW_BITS;
        localparam int YSH = (f == 0) ? 0 : (f == 1) ? 1 : (f == 2) ? 1 : SH_BITS;
        assign xs_tab[f] = SHIFT_W'(XSH);
        assign ys_tab[f] = SHIFT_W'(YSH);
    end

    // Select the entry and derive bit counts and masks.
    always_comb begin
        xs    = xs_tab[fmt];
        ys    = ys_tab[fmt];
        xbits = SHIFT_W'(CW_BITS) - xs;
        ybits = SHIFT_W'(CH_BITS) - ys;
        xmask = (32'd1 << xbits) - 32'd1;
        ymask = (32'd1 << ybits) - 32'd1;
    end
endmodule

// File: rtl/tvag_pack.sv
// Coordinate packer: range check, mirroring, optional XY swap, alignment
// shift and merge of the format and view fields. Combinational. Assumes the
// shifted offset fits below bit 27 for every format.
module tvag_pack #(
    parameter int COORD_W = 16,
    parameter int CW_BITS = 14,
    parameter int CH_BITS = 13
) (
    input  logic [1:0]                   fmt,
    input  logic [2:0]                   orient,
    input  logic [COORD_W-1:0]           x,
    input  logic [COORD_W-1:0]           y,
    input  logic [tvag_pkg::SHIFT_W-1:0] xs,
    input  logic [tvag_pkg::SHIFT_W-1:0] ys,
    input  logic [tvag_pkg::SHIFT_W-1:0] xbits,
    input  logic [tvag_pkg::SHIFT_W-1:0] ybits,
    input  logic [31:0]                  xmask,
    input  logic [31:0]                  ymask,
    output logic [31:0]                  addr,
    output logic                         in_range,
    output logic [31:0]                  stride
);
    import tvag_pkg::*;

    localparam int OFS_W = 27;

    logic [31:0] xw, yw, xm, ym, ofs, ofs_sh;

    // Range test, mirror, pack and merge of fields.
    always_comb begin
        xw       = 32'(x);
        yw       = 32'(y);
        in_range = (xw <= xmask) && (yw <= ymask);
        xm       = orient[OR_XINV] ? (xw ^ xmask) : xw;
        ym       = orient[OR_YINV] ? (yw ^ ymask) : yw;
        ofs      = orient[OR_FLIP] ? ((xm << ybits) + ym) : ((ym << xbits) + xm);
        ofs_sh   = ofs << (xs + ys);
        addr     = in_range ? {orient, fmt, ofs_sh[OFS_W-1:0]} : 32'd0;
    end

    // Stride of one line of the selected view.
    always_comb begin
        stride = orient[OR_FLIP] ? (32'd1 << (SHIFT_W'(CH_BITS) + xs))
                                 : (32'd1 << (SHIFT_W'(CW_BITS) + ys));
    end
endmodule

// File: rtl/tvag_top.sv
// Tiled view address generator top: one registered stage over the geometry
// decoder and the packer. Results appear one clock after in_valid and hold
// while no request is presented. Synchronous active-low reset.
module tvag_top #(
    parameter int COORD_W = 16,
    parameter int CW_BITS = 14,
    parameter int CH_BITS = 13,
    parameter int SW_BITS = 6,
    parameter int SH_BITS = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [1:0]         fmt_i,
    input  logic [2:0]         orient_i,
    input  logic [COORD_W-1:0] x_i,
    input  logic [COORD_W-1:0] y_i,
    output logic               out_valid,
    output logic [31:0]        addr_o,
    output logic               in_range_o,
    output logic [31:0]        stride_o
);
    import tvag_pkg::*;

    logic [SHIFT_W-1:0] xs, ys, xbits, ybits;
    logic [31:0]        xmask, ymask, addr_c, stride_c;
    logic               in_range_c;

    tvag_geom #(
        .CW_BITS(CW_BITS), .CH_BITS(CH_BITS),
        .SW_BITS(SW_BITS), .SH_BITS(SH_BITS)
    ) u_geom (
        .fmt(fmt_i), .xs(xs), .ys(ys), .xbits(xbits), .ybits(ybits),
        .xmask(xmask), .ymask(ymask)
    );

    tvag_pack #(
        .COORD_W(COORD_W), .CW_BITS(CW_BITS), .CH_BITS(CH_BITS)
    ) u_pack (
        .fmt(fmt_i), .orient(orient_i), .x(x_i), .y(y_i),
        .xs(xs), .ys(ys), .xbits(xbits), .ybits(ybits),
        .xmask(xmask), .ymask(ymask),
        .addr(addr_c), .in_range(in_range_c), .stride(stride_c)
    );

    // Strobe follows the request by one clock.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // Result registers load only on a request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_o     <= 32'd0;
            in_range_o <= 1'b0;
            stride_o   <= 32'd0;
        end else if (in_valid) begin
            addr_o     <= addr_c;
            in_range_o <= in_range_c;
            stride_o   <= stride_c;
        end
    end
endmodule

// File: rtl/tvag_checker.sv
// Checker for tvag_top: temporal properties over its ports, bound below.
module tvag_checker #(
    parameter int COORD_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic [1:0]         fmt_i,
    input logic [2:0]         orient_i,
    input logic [COORD_W-1:0] x_i,
    input logic [COORD_W-1:0] y_i,
    input logic               out_valid,
    input logic [31:0]        addr_o,
    input logic               in_range_o,
    input logic [31:0]        stride_o
);
    assert_strobe_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_strobe_drops_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(addr_o) && $stable(stride_o) && $stable(in_range_o)));
    assert_fmt_field_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (!in_range_o || addr_o[28:27] == $past(fmt_i)));
    assert_view_field_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (!in_range_o || addr_o[31:29] == $past(orient_i)));
    assert_reject_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !in_range_o) |-> (addr_o == 32'd0));
    assert_x_reject_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && x_i > 16'd16383) |=> !in_range_o);
    assert_stride_pow2_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($countones(stride_o) == 1));
endmodule

bind tvag_top tvag_checker #(.COORD_W(COORD_W)) u_tvag_checker (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fmt_i(fmt_i),
    .orient_i(orient_i), .x_i(x_i), .y_i(y_i), .out_valid(out_valid),
    .addr_o(addr_o), .in_range_o(in_range_o), .stride_o(stride_o)
);

// File: tb/tb_tvag_top.sv
// Bench for tvag_top: behavioural reference model, checks every result.
module tb_tvag_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  fmt_i = 2'd0;
    logic [2:0]  orient_i = 3'd0;
    logic [15:0] x_i = 16'd0;
    logic [15:0] y_i = 16'd0;
    logic        out_valid;
    logic [31:0] addr_o;
    logic        in_range_o;
    logic [31:0] stride_o;

    int n_tests = 0;
    int n_fail  = 0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    tvag_top dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fmt_i(fmt_i),
        .orient_i(orient_i), .x_i(x_i), .y_i(y_i), .out_valid(out_valid),
        .addr_o(addr_o), .in_range_o(in_range_o), .stride_o(stride_o)
    );

    // Reference model values
    longint e_addr, e_stride;
    int     e_ok;

    task automatic model(input int f, input int o, input longint x, input longint y);
        int xsh, ysh, xb, yb;
        longint xmax, ymax, xx, yy, ofs;
        xsh = (f == 2) ? 1 : (f == 3) ? 6 : 0;
        ysh = (f == 0) ? 0 : (f == 3) ? 6 : 1;
        xb = 14 - xsh;
        yb = 13 - ysh;
        xmax = (longint'(1) << xb) - 1;
        ymax = (longint'(1) << yb) - 1;
        e_stride = (o >= 4) ? (longint'(1) << (13 + xsh)) : (longint'(1) << (14 + ysh));
        e_ok = (x <= xmax && y <= ymax) ? 1 : 0;
        xx = (o % 2 == 1) ? xmax - x : x;
        yy = ((o / 2) % 2 == 1) ? ymax - y : y;
        if (o >= 4) ofs = xx * (longint'(1) << yb) + yy;
        else        ofs = yy * (longint'(1) << xb) + xx;
        ofs = ofs * (longint'(1) << (xsh + ysh));
        if (e_ok == 1) e_addr = longint'(o) * 64'h2000_0000 + longint'(f) * 64'h0800_0000 + ofs;
        else           e_addr = 0;
    endtask

    task automatic check(input logic ok, input string tag, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Present one request, compare one clock later at the falling edge.
    task automatic run(input int f, input int o, input int x, input int y, input string tag);
        in_valid = 1'b1; fmt_i = 2'(f); orient_i = 3'(o); x_i = 16'(x); y_i = 16'(y);
        model(f, o, x, y);
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid == 1'b1, "R1 out_valid", longint'(out_valid), 1);
        check(longint'(addr_o) == e_addr, tag, longint'(addr_o), e_addr);
        check(int'(in_range_o) == e_ok, "R5 in_range", longint'(in_range_o), longint'(e_ok));
        check(longint'(stride_o) == e_stride, "R9 stride", longint'(stride_o), e_stride);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state, while in reset
        check(out_valid == 1'b0 && addr_o == 0 && stride_o == 0 && in_range_o == 0,
              "R10 reset", longint'(addr_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0 && addr_o == 0 && stride_o == 0 && in_range_o == 0,
              "R10 after reset", longint'(stride_o), 0);

        // R7 plain packing, hand value
        run(0, 0, 1, 1, "R7 plain 8-bit");
        check(addr_o == 32'h0000_4001, "R7 hand value", longint'(addr_o), 64'h4001);
        // R8 alignment shift, hand value for 32-bit
        run(2, 0, 3, 2, "R8 32-bit");
        check(addr_o == 32'h1001_000C, "R8 hand value", longint'(addr_o), 64'h1001000C);
        // R2 format field for each format
        for (int f = 0; f < 4; f++) begin
            run(f, 0, 5, 3, "R2 format field");
            check(addr_o[28:27] == 2'(f), "R2 bits", longint'(addr_o[28:27]), longint'(f));
        end
        // R3 R6 R7 every orientation at both extremes for every format (R4 bit counts)
        for (int f = 0; f < 4; f++) begin
            for (int o = 0; o < 8; o++) begin
                int xmx, ymx;
                xmx = (1 << (14 - ((f == 2) ? 1 : (f == 3) ? 6 : 0))) - 1;
                ymx = (1 << (13 - ((f == 0) ? 0 : (f == 3) ? 6 : 1))) - 1;
                run(f, o, 0, 0, "R6 origin");
                check(addr_o[31:29] == 3'(o), "R3 view bits", longint'(addr_o[31:29]), longint'(o));
                run(f, o, xmx, ymx, "R4 max coords");
                run(f, o, xmx, 0, "R7 flip corner");
                run(f, o, 1, ymx, "R6 mirror corner");
                // R5 one above each mask, stride still reported (R9)
                run(f, o, xmx + 1, 0, "R5 x over");
                run(f, o, 0, ymx + 1, "R5 y over");
            end
        end
        // R1 hold: idle cycles keep the last result
        run(1, 5, 100, 50, "R1 last");
        begin
            longint held;
            held = longint'(addr_o);
            @(negedge clk);
            check(out_valid == 1'b0, "R1 strobe low", longint'(out_valid), 0);
            check(longint'(addr_o) == held, "R1 hold addr", longint'(addr_o), held);
        end
        // R4 mixed vectors
        for (int i = 0; i < 300; i++)
            run(int'($urandom % 4), int'($urandom % 8), int'($urandom & 32'h3FFF),
                int'($urandom & 32'h1FFF), "R4 random");
        // R1 back-to-back requests
        in_valid = 1'b1; fmt_i = 2'd0; orient_i = 3'd0; x_i = 16'd7; y_i = 16'd0;
        @(negedge clk);
        x_i = 16'd9;
        check(addr_o == 32'd7, "R1 pipelined first", longint'(addr_o), 7);
        @(negedge clk);
        in_valid = 1'b0;
        check(addr_o == 32'd9, "R1 pipelined second", longint'(addr_o), 9);
        done = 1'b1;
    end

    // Watchdog and summary
    initial begin
        for (int c = 0; c < 100000 && !done; c++) @(negedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule